// File: doc/BRIEF.md
# PWM Duty to Signed Amplitude Decoder

The decoder turns a pulse-width command from a system controller into a signed
10-bit amplitude for a motor drive path. It runs a triangular reference that
descends from 1023 to 0 and climbs back to 1023 on every clock. The reference
restarts at the top on each falling edge of the command. The point on the
triangle where the following rising edge lands sets the result. A short low
time (high duty) lands on the descending half and gives a positive amplitude.
A long low time (low duty) lands on the ascending half and gives a negative
amplitude, which the drive path reads as a request to brake actively.

A command held at one level for a whole reference period gives full scale:
+1023 when held high and -1023 when held low. The result repeats once per
period while the level does not change. The command period must come from the
same clock as the decoder. The command is resynchronised through two flops
before its edges are detected.

Each result leaves on a valid/ready stream. A result stays on the outputs until
it is taken (valid and ready high at the same clock edge). If a new result
arrives while the previous one is still waiting, the new one replaces it, so a
slow consumer always reads the latest command.

Top module: `pwm_amp_decoder`

## Requirements
- R1: The reference takes the value 1023 at the clock edge that detects a falling edge. It then steps down by one per clock to 0, then up by one per clock to 1023, and turns back down. One full period is 2046 clocks.
- R2: Let L be the number of clocks the command stays low before it rises. For 1 <= L <= 1024 the result is positive: amp_neg = 0 and amp_mag = 1024 - L. So L = 1 gives +1023 and L = 1024 gives 0.
- R3: For 1025 <= L <= 2047 the result is negative: amp_neg = 1 and amp_mag = L - 1024. So L = 1025 gives -1 and L = 2047 gives -1023.
- R4: A rising edge that arrives after the reference has already climbed back to its top since the last falling edge (L > 2047) gives -1023.
- R5: When the synchronised command stays high with no edge for 2046 clocks, a result of amp_neg = 0, amp_mag = 1023 is issued. It is issued again every further 2046 clocks while the command stays high.
- R6: When the synchronised command stays low with no edge for 2046 clocks, a result of amp_neg = 1, amp_mag = 1023 is issued. It is issued again every further 2046 clocks while the command stays low.
- R7: A rising edge that comes before the first falling edge after reset produces no result.
- R8: After reset, amp_valid is low.
- R9: amp_valid stays high, and the pending result stays unchanged, until a clock edge sees amp_ready high. A newer result that arrives meanwhile replaces the pending one.
- R10: amp_neg = 1 marks a negative (braking) amplitude and amp_mag holds the magnitude. Zero is always given as amp_neg = 0, so a negative result never has a magnitude of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the time base of the command |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Pulse-width command, asynchronous to clk |
| amp_ready | input | 1 | Consumer accepts the result at this edge |
| amp_valid | output | 1 | A result is pending on amp_neg/amp_mag |
| amp_neg | output | 1 | Sign of the result, 1 = negative (brake) |
| amp_mag | output | 10 | Magnitude of the result, 0..1023 |

## Verification
The properties assume that pwm_in holds each level for at least one clock, so
that the synchroniser sees every edge. They place no limit on amp_ready, which
may stall for any length of time. The stimulus changes pwm_in only at falling
clock edges and gives every level a whole number of clocks. This keeps the low
times exact, so each expected amplitude follows directly from L. Low and high
times sit either well inside one reference period or at several whole periods,
so the full-scale results from a held level are counted without ambiguity.

// File: rtl/pwm_amp_pkg.sv
package pwm_amp_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} tri_dir_t;
endpackage

// File: rtl/pwmdec_sync_edge.sv
module pwmdec_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '0;
      last <= 1'b0;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      last <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];
  assign rise  = level & ~last;
  assign fall  = ~level & last;
endmodule

// File: rtl/pwmdec_tri_ref.sv
module pwmdec_tri_ref
  import pwm_amp_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count,
  output tri_dir_t     dir,
  output logic         lapped
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= TOP;
      dir    <= DIR_DOWN;
      lapped <= 1'b0;
    end else if (restart) begin
      count  <= TOP;
      dir    <= DIR_DOWN;
      lapped <= 1'b0;
    end else if (dir == DIR_DOWN) begin
      if (count == '0) begin
        dir   <= DIR_UP;
        count <= W'(1);
      end else begin
        count <= count - W'(1);
      end
    end else begin
      if (count == TOP) begin
        dir    <= DIR_DOWN;
        count  <= TOP - W'(1);
        lapped <= 1'b1;
      end else begin
        count <= count + W'(1);
      end
    end
  end
endmodule

// File: rtl/pwmdec_stuck_det.sv
module pwmdec_stuck_det #(
  parameter int SPAN = 2046
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  output logic fire
);
  localparam int CW = $clog2(SPAN);
  logic [CW-1:0] idle;

  assign fire = !activity && (idle == CW'(SPAN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                idle <= '0;
    else if (activity || fire) idle <= '0;
    else                       idle <= idle + CW'(1);
  end
endmodule

// File: rtl/pwmdec_decide.sv
module pwmdec_decide
  import pwm_amp_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         fall,
  input  logic         level,
  input  logic         stuck,
  input  logic [W-1:0] count,
  input  tri_dir_t     dir,
  input  logic         lapped,
  output logic         synced,
  output logic         evt,
  output logic         evt_neg,
  output logic [W-1:0] evt_mag
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)    synced <= 1'b0;
    else if (fall) synced <= 1'b1;
  end

  always_comb begin
    evt     = 1'b0;
    evt_neg = 1'b0;
    evt_mag = '0;
    if (rise && synced) begin
      evt = 1'b1;
      if (lapped) begin
        evt_neg = 1'b1;
        evt_mag = TOP;
      end else begin
        evt_neg = (dir == DIR_UP);
        evt_mag = count;
      end
    end else if (stuck) begin
      evt     = 1'b1;
      evt_neg = !level;
      evt_mag = TOP;
    end
  end
endmodule

// File: rtl/pwmdec_out_hold.sv
module pwmdec_out_hold #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         evt_neg,
  input  logic [W-1:0] evt_mag,
  input  logic         ready,
  output logic         valid,
  output logic         neg,
  output logic [W-1:0] mag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      neg   <= 1'b0;
      mag   <= '0;
    end else if (evt) begin
      valid <= 1'b1;
      neg   <= evt_neg;
      mag   <= evt_mag;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_amp_decoder.sv
module pwm_amp_decoder
  import pwm_amp_pkg::*;
#(
  parameter int W           = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm_in,
  input  logic         amp_ready,
  output logic         amp_valid,
  output logic         amp_neg,
  output logic [W-1:0] amp_mag
);
  localparam int TOP_VAL = (1 << W) - 1;
  localparam int PERIOD  = 2 * TOP_VAL;

  logic         lvl_s, rise_s, fall_s, stuck;
  logic [W-1:0] tri_count;
  tri_dir_t     tri_dir;
  logic         tri_lapped;
  logic         synced, evt, evt_neg;
  logic [W-1:0] evt_mag;

  pwmdec_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pwm_in),
    .level(lvl_s), .rise(rise_s), .fall(fall_s)
  );

  pwmdec_tri_ref #(.W(W)) u_tri (
    .clk(clk), .rst_n(rst_n), .restart(fall_s),
    .count(tri_count), .dir(tri_dir), .lapped(tri_lapped)
  );

  pwmdec_stuck_det #(.SPAN(PERIOD)) u_stuck (
    .clk(clk), .rst_n(rst_n), .activity(rise_s | fall_s), .fire(stuck)
  );

  pwmdec_decide #(.W(W)) u_decide (
    .clk(clk), .rst_n(rst_n), .rise(rise_s), .fall(fall_s), .level(lvl_s),
    .stuck(stuck), .count(tri_count), .dir(tri_dir), .lapped(tri_lapped),
    .synced(synced), .evt(evt), .evt_neg(evt_neg), .evt_mag(evt_mag)
  );

  pwmdec_out_hold #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .evt(evt), .evt_neg(evt_neg), .evt_mag(evt_mag),
    .ready(amp_ready), .valid(amp_valid), .neg(amp_neg), .mag(amp_mag)
  );
endmodule

// File: rtl/pwmdec_checker.sv
module pwmdec_checker
  import pwm_amp_pkg::*;
#(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         amp_ready,
  input logic         amp_valid,
  input logic         amp_neg,
  input logic [W-1:0] amp_mag,
  input logic         fall_s,
  input logic         rise_s,
  input logic         lvl_s,
  input logic         stuck,
  input logic         synced,
  input logic         evt,
  input logic [W-1:0] tri_count,
  input tri_dir_t     tri_dir
);
  localparam logic [W-1:0] TOP = '1;

  // R1: restart at the top, heading down
  p_restart_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_s |=> (tri_count == TOP && tri_dir == DIR_DOWN));

  // R10: a negative result never carries zero magnitude
  p_neg_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && amp_neg) |-> (amp_mag != '0));

  // R9: valid held under stall
  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && !amp_ready) |=> amp_valid);

  // R9: data held under stall unless replaced
  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && !amp_ready && !evt) |=> ($stable(amp_mag) && $stable(amp_neg)));

  // R9: valid drops only after acceptance
  p_drop_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(amp_valid) |-> $past(amp_ready));

  // R7: no result from a rise before the first fall
  p_no_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_s && !synced) |=> !$rose(amp_valid));

  // R5 / R6: held level yields full scale with matching sign
  p_stuck_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stuck |=> (amp_valid && amp_mag == TOP && amp_neg == !$past(lvl_s)));
endmodule

bind pwm_amp_decoder pwmdec_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .amp_ready(amp_ready), .amp_valid(amp_valid),
  .amp_neg(amp_neg), .amp_mag(amp_mag), .fall_s(fall_s), .rise_s(rise_s),
  .lvl_s(lvl_s), .stuck(stuck), .synced(synced), .evt(evt),
  .tri_count(tri_count), .tri_dir(tri_dir)
);

// File: tb/pwm_amp_decoder_test.sv
module pwm_amp_decoder_test;
  localparam int SPAN = 2046;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic       amp_ready = 1'b1;
  logic       amp_valid, amp_neg;
  logic [9:0] amp_mag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit    exp_neg[$];
  int    exp_mag[$];
  string exp_tag[$];

  bit cur_level = 1'b0;
  bit model_synced = 1'b0;
  bit suppress = 1'b0;
  int last_low = 0;

  always #2.5 clk = ~clk;

  pwm_amp_decoder uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .amp_ready(amp_ready),
    .amp_valid(amp_valid), .amp_neg(amp_neg), .amp_mag(amp_mag)
  );

  task automatic push(bit n, int m, string t);
    if (!suppress) begin
      exp_neg.push_back(n);
      exp_mag.push_back(m);
      exp_tag.push_back(t);
    end
  endtask

  task automatic push_rise(int L);
    if (L <= 1024)      push(1'b0, 1024 - L, "R2");
    else if (L == 2046) push(1'b1, L - 1024, "R1");
    else if (L <= 2047) push(1'b1, L - 1024, "R3");
    else                push(1'b1, 1023, "R4");
  endtask

  // drive one level for n clocks, predicting its results first
  task automatic seg(bit v, int n);
    if (v && !cur_level && model_synced) push_rise(last_low);
    if (!v && cur_level) model_synced = 1'b1;
    for (int k = 1; k <= (n - 1) / SPAN; k++)
      push(!v, 1023, v ? "R5" : "R6");
    if (!v) last_low = n;
    cur_level = v;
    @(negedge clk);
    pwm_in = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished && amp_valid && amp_ready) begin
      checks++;
      if (exp_mag.size() == 0) begin
        errors++;
        $display("FAIL unexpected result actual neg=%0d mag=%0d expected none",
                 amp_neg, amp_mag);
      end else begin
        if (amp_neg != exp_neg[0] || int'(amp_mag) != exp_mag[0]) begin
          errors++;
          $display("FAIL %s actual neg=%0d mag=%0d expected neg=%0d mag=%0d",
                   exp_tag[0], amp_neg, amp_mag, exp_neg[0], exp_mag[0]);
        end
        void'(exp_neg.pop_front());
        void'(exp_mag.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000 && !finished) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(amp_valid == 1'b0, "R8 reset valid", amp_valid, 0);

    // R7: rise before any fall is ignored
    seg(1'b0, 20);
    seg(1'b1, 100);
    check(amp_valid == 1'b0 && exp_mag.size() == 0, "R7 early rise", amp_valid, 0);

    // R2 / R10 descending half, R3 / R1 ascending half
    seg(1'b0, 1);    seg(1'b1, 300);
    seg(1'b0, 1024); seg(1'b1, 300);
    seg(1'b0, 500);  seg(1'b1, 300);
    seg(1'b0, 1025); seg(1'b1, 300);
    seg(1'b0, 1500); seg(1'b1, 400);
    seg(1'b0, 2040); seg(1'b1, 100);
    seg(1'b0, 2046); seg(1'b1, 100);
    seg(1'b0, 2047); seg(1'b1, 100);
    // R4 / R5 / R6: long held levels
    seg(1'b0, 5000); seg(1'b1, 5000);

    // R9: stall, newer result replaces pending one
    seg(1'b0, 100);
    repeat (5) @(negedge clk);
    amp_ready = 1'b0;
    suppress = 1'b1;
    seg(1'b1, 100);
    seg(1'b0, 200);
    suppress = 1'b0;
    seg(1'b1, 100);
    check(amp_valid == 1'b1, "R9 held valid", amp_valid, 1);
    check(amp_neg == 1'b0 && amp_mag == 10'd824, "R9 latest value", amp_mag, 824);
    repeat (3) @(negedge clk);
    check(amp_valid == 1'b1 && amp_mag == 10'd824, "R9 still held", amp_mag, 824);
    amp_ready = 1'b1;
    seg(1'b0, 50);
    repeat (10) @(negedge clk);
    check(exp_mag.size() == 0, "R9 all results delivered", exp_mag.size(), 0);
    check(amp_valid == 1'b0, "R9 valid cleared", amp_valid, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule